// File: doc/BRIEF.md
# Coprocessor Local-Memory DMA Engine

This block copies 32-bit words between a large main memory and a coprocessor's two local memories: a 4 KB data memory and a 4 KB instruction memory. Software programs a local byte address, a main-memory byte address and a packed length word through a small register port. Writing the length word at the inbound offset copies main memory into local memory. Writing it at the outbound offset copies local memory into main memory. Each write starts one transfer.

The engine works out the number of words from the length field. It shortens the transfer so that it never crosses the end of the 4 KB local page. Address bit 12 picks the local memory. After one setup cycle the engine moves one word per clock and pulses `done` once the last word is written. When the transfer ends, the local address register has advanced by the number of bytes moved, so back-to-back transfers continue where the last one stopped. All three memories are synchronous RAMs with one cycle of read latency. The multi-row stride fields are stored and read back but have no effect on transfers.

Top module: `spdma_top`

## Requirements
- R1: After reset every readable register (offset 0 local address, 1 main address, 2 and 3 length word) reads zero.
- R2: The length word reads back unchanged at both offset 2 and offset 3, with the stride skip in bits 31:20, the row count in bits 19:12 and the length in bits 11:0. Writing it with any skip or count value changes nothing about the transfer.
- R3: Offsets 4 (queue-full status) and 5 (busy status) always read zero, including while a transfer runs.
- R4: Bits 1:0 of the local and main address registers are dropped on write and read back as zero. Transfers start at the aligned word.
- R5: The requested size is (length >> 2) + 1 words, i.e. the length field is a byte count minus one, rounded up to whole words.
- R6: If the request would pass the end of the 4 KB local page, it is cut to 0x1000 minus bits 11:0 of the local address.
- R7: Local address bit 12 = 0 targets the data memory and bit 12 = 1 targets the instruction memory. At most one memory is written per cycle.
- R8: Writing offset 2 copies main memory into local memory. Writing offset 3 copies local memory into main memory. Word i of a transfer uses main word address (main address >> 2) + i.
- R9: The local word index starts at local address bits 11:2 and advances by one per word, modulo 1024.
- R10: When a transfer ends, the local address register equals its old value plus the bytes moved, modulo 2^13. The main address register is unchanged.
- R11: The first word is read two cycles after the starting write. One word then moves per clock. `done` is a one-cycle pulse in the cycle after the last write, so it rises N+2 clock edges after the starting write for an N-word transfer.
- R12: While a transfer is in progress, all register writes, including a second start, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| done | output | 1 | One-cycle pulse when a transfer completes |
| mainAddr | output | MAIN_AW-2 | Main memory word address |
| mainRdEn | output | 1 | Main memory read enable |
| mainRdData | input | 32 | Main memory read data, one cycle after mainRdEn |
| mainWrEn | output | 1 | Main memory write enable |
| mainWrData | output | 32 | Main memory write data |
| dmemAddr | output | IDX_W | Data memory word index |
| dmemRdEn | output | 1 | Data memory read enable |
| dmemRdData | input | 32 | Data memory read data, one cycle after dmemRdEn |
| dmemWrEn | output | 1 | Data memory write enable |
| dmemWrData | output | 32 | Data memory write data |
| imemAddr | output | IDX_W | Instruction memory word index |
| imemRdEn | output | 1 | Instruction memory read enable |
| imemRdData | input | 32 | Instruction memory read data, one cycle after imemRdEn |
| imemWrEn | output | 1 | Instruction memory write enable |
| imemWrData | output | 32 | Instruction memory write data |

## Verification
Some properties hold on every cycle, and the assertions check those. Each memory write must follow a read of the opposite side one cycle earlier. Only one memory may be read or written per cycle. Consecutive local writes must step the word index by one modulo 1024. `done` must last a single cycle, and the two status offsets must read zero. Other behaviour depends on a whole transfer, so only the bench scenarios can show it. That covers the clip at the page end, the word count derived from the length field, the data moved to the correct memory, the address advance after completion, the exact cycle of `done`, and writes ignored mid-transfer. A scoreboard compares every memory write against a list the bench computes beforehand.

// File: rtl/spdma_pkg.sv
package spdma_pkg;

  // register word offsets
  localparam logic [2:0] REG_LOCAL   = 3'd0;
  localparam logic [2:0] REG_MAIN    = 3'd1;
  localparam logic [2:0] REG_LEN_IN  = 3'd2;  // start main -> local
  localparam logic [2:0] REG_LEN_OUT = 3'd3;  // start local -> main
  localparam logic [2:0] REG_FULL    = 3'd4;
  localparam logic [2:0] REG_BUSY    = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } spdmaState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic setup;   // latch pointers and clipped size
    logic issue;   // read one source word this cycle
    logic last;    // this issue is the final word
  } spdmaStrobes_t;

endpackage

// File: rtl/spdma_ctrl.sv
module spdma_ctrl
  import spdma_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] wordCount,
  output spdmaStrobes_t    stb,
  output logic             engaged
);

  spdmaState_e stateQ;
  logic [CNT_W-1:0] remainQ;

  always_comb begin
    stb.setup = (stateQ == ST_SETUP);
    stb.issue = (stateQ == ST_RUN);
    stb.last  = (stateQ == ST_RUN) && (remainQ == CNT_W'(1));
    engaged   = (stateQ != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      remainQ <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (start) stateQ <= ST_SETUP;
        end
        ST_SETUP: begin
          remainQ <= wordCount;
          stateQ  <= ST_RUN;
        end
        ST_RUN: begin
          remainQ <= remainQ - CNT_W'(1);
          if (remainQ == CNT_W'(1)) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spdma_datapath.sv
module spdma_datapath
  import spdma_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int MAIN_AW = 24,
  localparam int PAGE_BITS = IDX_W + 2,
  localparam int LOCAL_AW  = PAGE_BITS + 1,
  localparam int CNT_W     = IDX_W + 1,
  localparam int MWORD_W   = MAIN_AW - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrAccept,
  input  logic [2:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  spdmaStrobes_t      stb,
  output logic [CNT_W-1:0]   wordCount,
  output logic               pipeBusy,
  output logic               done,
  output logic [MWORD_W-1:0] mainAddr,
  output logic               mainRdEn,
  input  logic [31:0]        mainRdData,
  output logic               mainWrEn,
  output logic [31:0]        mainWrData,
  output logic [IDX_W-1:0]   dmemAddr,
  output logic               dmemRdEn,
  input  logic [31:0]        dmemRdData,
  output logic               dmemWrEn,
  output logic [31:0]        dmemWrData,
  output logic [IDX_W-1:0]   imemAddr,
  output logic               imemRdEn,
  input  logic [31:0]        imemRdData,
  output logic               imemWrEn,
  output logic [31:0]        imemWrData
);

  // programmable registers
  logic [LOCAL_AW-1:0] localAddrQ;
  logic [MAIN_AW-1:0]  mainAddrQ;
  logic [31:0]         lenQ;
  logic                dirInQ;     // 1: main -> local

  // walking state
  logic [IDX_W-1:0]    idxQ;
  logic                selQ;       // 1: instruction memory
  logic [MWORD_W-1:0]  mainPtrQ;
  logic [LOCAL_AW-1:0] bytesQ;

  // one-stage read-to-write pipe
  logic                pipeValidQ;
  logic                pipeLastQ;
  logic [IDX_W-1:0]    pipeIdxQ;
  logic [MWORD_W-1:0]  pipeMainQ;
  logic                doneQ;

  // size computation and page clip
  logic [CNT_W-1:0]    reqWords;
  logic [LOCAL_AW-1:0] reqBytes;
  logic [LOCAL_AW-1:0] roomBytes;
  logic [LOCAL_AW-1:0] clipBytes;

  always_comb begin
    reqWords  = {1'b0, lenQ[PAGE_BITS-1:2]} + CNT_W'(1);
    reqBytes  = {reqWords, 2'b00};
    roomBytes = LOCAL_AW'(1 << PAGE_BITS) - {1'b0, localAddrQ[PAGE_BITS-1:0]};
    clipBytes = (reqBytes > roomBytes) ? roomBytes : reqBytes;
    wordCount = clipBytes[LOCAL_AW-1:2];
  end

  always_comb begin
    unique case (regAddr)
      REG_LOCAL:   regRdData = 32'(localAddrQ);
      REG_MAIN:    regRdData = 32'(mainAddrQ);
      REG_LEN_IN,
      REG_LEN_OUT: regRdData = lenQ;
      default:     regRdData = '0;  // includes full and busy status
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      localAddrQ <= '0;
      mainAddrQ  <= '0;
      lenQ       <= '0;
      dirInQ     <= 1'b0;
      idxQ       <= '0;
      selQ       <= 1'b0;
      mainPtrQ   <= '0;
      bytesQ     <= '0;
      pipeValidQ <= 1'b0;
      pipeLastQ  <= 1'b0;
      pipeIdxQ   <= '0;
      pipeMainQ  <= '0;
      doneQ      <= 1'b0;
    end else begin
      if (wrAccept) begin
        unique case (regAddr)
          REG_LOCAL:   localAddrQ <= {regWrData[LOCAL_AW-1:2], 2'b00};
          REG_MAIN:    mainAddrQ  <= {regWrData[MAIN_AW-1:2], 2'b00};
          REG_LEN_IN:  begin lenQ <= regWrData; dirInQ <= 1'b1; end
          REG_LEN_OUT: begin lenQ <= regWrData; dirInQ <= 1'b0; end
          default: ;
        endcase
      end

      if (stb.setup) begin
        idxQ     <= localAddrQ[PAGE_BITS-1:2];
        selQ     <= localAddrQ[PAGE_BITS];
        mainPtrQ <= mainAddrQ[MAIN_AW-1:2];
        bytesQ   <= clipBytes;
      end else if (stb.issue) begin
        idxQ     <= idxQ + IDX_W'(1);
        mainPtrQ <= mainPtrQ + MWORD_W'(1);
      end

      pipeValidQ <= stb.issue;
      pipeLastQ  <= stb.last;
      if (stb.issue) begin
        pipeIdxQ  <= idxQ;
        pipeMainQ <= mainPtrQ;
      end

      doneQ <= pipeValidQ & pipeLastQ;
      if (pipeValidQ & pipeLastQ) localAddrQ <= localAddrQ + bytesQ;
    end
  end

  // per-bank port enables
  logic [1:0] bankRd;
  logic [1:0] bankWr;
  logic [IDX_W-1:0] bankAddr;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bankRd[b] = stb.issue & ~dirInQ & (selQ == 1'(b));
    assign bankWr[b] = pipeValidQ & dirInQ & (selQ == 1'(b));
  end

  logic [31:0] moveData;

  always_comb begin
    bankAddr = dirInQ ? pipeIdxQ : idxQ;
    moveData = dirInQ ? mainRdData : (selQ ? imemRdData : dmemRdData);

    mainAddr   = dirInQ ? mainPtrQ : pipeMainQ;
    mainRdEn   = stb.issue & dirInQ;
    mainWrEn   = pipeValidQ & ~dirInQ;
    mainWrData = moveData;

    dmemAddr   = bankAddr;
    dmemRdEn   = bankRd[0];
    dmemWrEn   = bankWr[0];
    dmemWrData = moveData;

    imemAddr   = bankAddr;
    imemRdEn   = bankRd[1];
    imemWrEn   = bankWr[1];
    imemWrData = moveData;

    pipeBusy   = pipeValidQ;
    done       = doneQ;
  end

endmodule

// File: rtl/spdma_top.sv
module spdma_top
  import spdma_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int MAIN_AW = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [2:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 done,
  output logic [MAIN_AW-3:0]   mainAddr,
  output logic                 mainRdEn,
  input  logic [31:0]          mainRdData,
  output logic                 mainWrEn,
  output logic [31:0]          mainWrData,
  output logic [IDX_W-1:0]     dmemAddr,
  output logic                 dmemRdEn,
  input  logic [31:0]          dmemRdData,
  output logic                 dmemWrEn,
  output logic [31:0]          dmemWrData,
  output logic [IDX_W-1:0]     imemAddr,
  output logic                 imemRdEn,
  input  logic [31:0]          imemRdData,
  output logic                 imemWrEn,
  output logic [31:0]          imemWrData
);

  localparam int CNT_W = IDX_W + 1;

  spdmaStrobes_t    stb;
  logic [CNT_W-1:0] wordCount;
  logic             engaged;
  logic             pipeBusy;
  logic             busy;
  logic             wrAccept;
  logic             start;

  assign busy     = engaged | pipeBusy;
  assign wrAccept = regWrEn & ~busy;
  assign start    = wrAccept & ((regAddr == REG_LEN_IN) | (regAddr == REG_LEN_OUT));

  spdma_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wordCount (wordCount),
    .stb       (stb),
    .engaged   (engaged)
  );

  spdma_datapath #(.IDX_W(IDX_W), .MAIN_AW(MAIN_AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrAccept   (wrAccept),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .stb        (stb),
    .wordCount  (wordCount),
    .pipeBusy   (pipeBusy),
    .done       (done),
    .mainAddr   (mainAddr),
    .mainRdEn   (mainRdEn),
    .mainRdData (mainRdData),
    .mainWrEn   (mainWrEn),
    .mainWrData (mainWrData),
    .dmemAddr   (dmemAddr),
    .dmemRdEn   (dmemRdEn),
    .dmemRdData (dmemRdData),
    .dmemWrEn   (dmemWrEn),
    .dmemWrData (dmemWrData),
    .imemAddr   (imemAddr),
    .imemRdEn   (imemRdEn),
    .imemRdData (imemRdData),
    .imemWrEn   (imemWrEn),
    .imemWrData (imemWrData)
  );

endmodule

// File: rtl/spdma_chk.sv
module spdma_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       regAddr,
  input logic [31:0]      regRdData,
  input logic             done,
  input logic             mainRdEn,
  input logic             mainWrEn,
  input logic [IDX_W-1:0] dmemAddr,
  input logic             dmemRdEn,
  input logic             dmemWrEn,
  input logic [IDX_W-1:0] imemAddr,
  input logic             imemRdEn,
  input logic             imemWrEn
);

  // R3
  status_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd4 || regAddr == 3'd5) |-> regRdData == 32'd0);

  // R7
  one_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mainWrEn, dmemWrEn, imemWrEn}));

  // R7
  one_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mainRdEn, dmemRdEn, imemRdEn}));

  // R8
  inbound_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmemWrEn || imemWrEn) |-> $past(mainRdEn));

  // R8
  outbound_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainWrEn |-> $past(dmemRdEn || imemRdEn));

  // R9
  dmem_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmemWrEn && $past(dmemWrEn)) |-> dmemAddr == $past(dmemAddr) + IDX_W'(1));

  // R9
  imem_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (imemWrEn && $past(imemWrEn)) |-> imemAddr == $past(imemAddr) + IDX_W'(1));

  // R11
  word_per_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    mainRdEn |=> (dmemWrEn || imemWrEn));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind spdma_top spdma_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .done      (done),
  .mainRdEn  (mainRdEn),
  .mainWrEn  (mainWrEn),
  .dmemAddr  (dmemAddr),
  .dmemRdEn  (dmemRdEn),
  .dmemWrEn  (dmemWrEn),
  .imemAddr  (imemAddr),
  .imemRdEn  (imemRdEn),
  .imemWrEn  (imemWrEn)
);

// File: tb/sim_spdma_top.sv
`timescale 1ns/1ps
module sim_spdma_top;

  localparam int IDX_W   = 10;
  localparam int MAIN_AW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        done;
  logic [MAIN_AW-3:0] mainAddr;
  logic        mainRdEn, mainWrEn;
  logic [31:0] mainRdData, mainWrData;
  logic [IDX_W-1:0] dmemAddr, imemAddr;
  logic        dmemRdEn, dmemWrEn, imemRdEn, imemWrEn;
  logic [31:0] dmemRdData, dmemWrData, imemRdData, imemWrData;

  spdma_top #(.IDX_W(IDX_W), .MAIN_AW(MAIN_AW)) u0 (.*);

  // memory models
  logic [31:0] mainMem [0:4095];
  logic [31:0] dmem    [0:1023];
  logic [31:0] imem    [0:1023];

  initial begin
    for (int i = 0; i < 4096; i++) mainMem[i] = 32'hA5000000 ^ (i * 32'h00010103);
    for (int i = 0; i < 1024; i++) begin
      dmem[i] = 32'hD0000000 | i;
      imem[i] = 32'h1E000000 | (i * 7);
    end
  end

  always @(posedge clk) begin
    if (mainRdEn) mainRdData <= mainMem[mainAddr[11:0]];
    if (mainWrEn) mainMem[mainAddr[11:0]] <= mainWrData;
    if (dmemRdEn) dmemRdData <= dmem[dmemAddr];
    if (dmemWrEn) dmem[dmemAddr] <= dmemWrData;
    if (imemRdEn) imemRdData <= imem[imemAddr];
    if (imemWrEn) imem[imemAddr] <= imemWrData;
  end

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: {target(0 main,1 dmem,2 imem), addr[11:0], data[31:0]}
  logic [45:0] expQ [$];

  always @(negedge clk) begin
    if (rstN) begin
      if (int'(mainWrEn) + int'(dmemWrEn) + int'(imemWrEn) > 1)
        check(0, "R7 multiple writes", 64'(1), 64'(0));
      if (mainWrEn || dmemWrEn || imemWrEn) begin
        logic [45:0] act;
        if (mainWrEn)      act = {2'd0, mainAddr[11:0], mainWrData};
        else if (dmemWrEn) act = {2'd1, 2'b00, dmemAddr, dmemWrData};
        else               act = {2'd2, 2'b00, imemAddr, imemWrData};
        if (expQ.size() == 0) begin
          check(0, "R12 unexpected write", 64'(act), 64'(0));
        end else begin
          logic [45:0] exp;
          exp = expQ.pop_front();
          check(act == exp, "R8 write target/addr/data", 64'(act), 64'(exp));
        end
      end
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  // pushes expected writes, programs registers; returns word count and new local address
  task automatic launch(input bit toLocal, input int la, input int ma, input logic [31:0] lenW,
                        output int n, output int newLocal);
    int al, offs, words, room, bytes, sel, mw, lidx;
    logic [31:0] d;
    al = la & 'h1FFC;
    offs = al & 'hFFF;
    words = (int'(lenW[11:0]) >> 2) + 1;
    room = 4096 - offs;
    bytes = (words * 4 > room) ? room : words * 4;
    n = bytes / 4;
    sel = (al >> 12) & 1;
    newLocal = (al + bytes) & 'h1FFF;
    for (int i = 0; i < n; i++) begin
      lidx = ((offs >> 2) + i) & 1023;
      mw = ((ma & 'hFFFFFC) >> 2) + i;
      if (toLocal) begin
        d = mainMem[mw & 4095];
        expQ.push_back({(sel != 0) ? 2'd2 : 2'd1, 12'(lidx), d});
      end else begin
        d = (sel != 0) ? imem[lidx] : dmem[lidx];
        expQ.push_back({2'd0, 12'(mw), d});
      end
    end
    writeReg(3'd0, 32'(la));
    writeReg(3'd1, 32'(ma));
    writeReg(toLocal ? 3'd2 : 3'd3, lenW);
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk);
      #1 cyc++;
    end while (!done && cyc < 5000);
  endtask

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 64'(0), 64'(1));
    finishRun();
  end

  initial begin
    int n, nl, cyc;
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values, R3 status offsets
    for (int a = 0; a < 4; a++) begin
      readReg(3'(a), v);
      check(v == 0, "R1 reset value", 64'(v), 64'(0));
    end
    readReg(3'd4, v); check(v == 0, "R3 full reads zero", 64'(v), 64'(0));
    readReg(3'd5, v); check(v == 0, "R3 busy reads zero", 64'(v), 64'(0));

    // R8 inbound to data memory, R5 length 15 -> 4 words, R11 timing
    launch(1, 'h0000, 'h100, 32'h0000000F, n, nl);
    waitDone(cyc);
    check(n == 4, "R5 word count", 64'(n), 64'(4));
    check(cyc == n + 2, "R11 done timing", 64'(cyc), 64'(n + 2));
    readReg(3'd0, v); check(v == 32'(nl), "R10 local advance", 64'(v), 64'(nl));
    readReg(3'd1, v); check(v == 32'h100, "R10 main unchanged", 64'(v), 64'h100);

    // R7 outbound from instruction memory, R5 length 30 -> 8 words
    launch(0, 'h1020, 'h200, 32'h0000001E, n, nl);
    waitDone(cyc);
    check(cyc == n + 2, "R11 done timing outbound", 64'(cyc), 64'(n + 2));
    readReg(3'd0, v); check(v == 32'(nl), "R10 local advance imem", 64'(v), 64'(nl));

    // R6 clip at page end, R9 index walk 1020..1023
    launch(1, 'h0FF0, 'h800, 32'h00000FFF, n, nl);
    waitDone(cyc);
    check(n == 4, "R6 clipped count", 64'(n), 64'(4));
    check(cyc == 6, "R6 clipped timing", 64'(cyc), 64'(6));
    readReg(3'd0, v); check(v == 32'h1000, "R6 local at page end", 64'(v), 64'h1000);

    // R2 packing readback with stride fields, no effect on size
    launch(0, 'h0104, 'h300, 32'h5A7C3007, n, nl);
    waitDone(cyc);
    check(cyc == 4, "R2 stride fields ignored", 64'(cyc), 64'(4));
    readReg(3'd2, v); check(v == 32'h5A7C3007, "R2 readback offset 2", 64'(v), 64'h5A7C3007);
    readReg(3'd3, v); check(v == 32'h5A7C3007, "R2 readback offset 3", 64'(v), 64'h5A7C3007);

    // R4 unaligned addresses, R5 length 0 -> 1 word
    launch(1, 'h0107, 'h30B, 32'h00000000, n, nl);
    waitDone(cyc);
    check(cyc == 3, "R5 single word", 64'(cyc), 64'(3));
    readReg(3'd1, v); check(v == 32'h308, "R4 main aligned", 64'(v), 64'h308);
    readReg(3'd0, v); check(v == 32'h108, "R4 local aligned then advanced", 64'(v), 64'h108);
    writeReg(3'd0, 32'h0000020B);
    readReg(3'd0, v); check(v == 32'h208, "R4 local low bits dropped", 64'(v), 64'h208);

    // R12 writes ignored mid-transfer
    launch(1, 'h0000, 'h000, 32'h000003FF, n, nl);
    repeat (5) @(posedge clk);
    readReg(3'd5, v); check(v == 0, "R3 busy zero during transfer", 64'(v), 64'(0));
    writeReg(3'd0, 32'h00000800);
    writeReg(3'd1, 32'h00000400);
    writeReg(3'd3, 32'h00000003);
    waitDone(cyc);
    check(done == 1'b1, "R11 done seen", 64'(done), 64'(1));
    readReg(3'd0, v); check(v == 32'h400, "R12 local write ignored", 64'(v), 64'h400);
    readReg(3'd1, v); check(v == 32'h000, "R12 main write ignored", 64'(v), 64'h0);
    readReg(3'd2, v); check(v == 32'h3FF, "R12 length write ignored", 64'(v), 64'h3FF);
    repeat (20) @(posedge clk);
    check(expQ.size() == 0, "R12 no extra transfer", 64'(expQ.size()), 64'(0));

    finishRun();
  end

endmodule